// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block is a 10-bit up-counting timer with two compare values. The period value can return the counter to zero when the count reaches it. The match value also raises its own event. A clear-select input chooses which of the two comparators resets the counter. Each comparator sets a sticky flag. Software clears a flag by pulsing a write-one-to-clear input.

A single output pin follows the match-value comparator only. On each match it can be driven high, driven low, toggled or left alone. A rising edge on the enable input loads the programmed initial level into the pin state and restarts the count from zero. A pause input freezes the counter. A polarity input inverts the final pin.

Top module: `tmr_cmp_out`

## Requirements
- R1: While enabled and not paused, the counter advances by one per clock. When no clear applies it wraps from 0x3FF to 0.
- R2: With clr_sel_i=0, a count equal to a nonzero per_i returns the counter to 0 on the next clock, so the period is per_i+1 clocks. per_i=0 produces no period match, and the counter wraps at overflow.
- R3: With clr_sel_i=1, a count equal to cmp_a_i returns the counter to 0 on the next clock. flag_p_o is never set in this mode, even when per_i is below cmp_a_i.
- R4: cmp_a_i=0 is invalid. It produces no match event, so flag_a_o stays clear and the pin does not change.
- R5: Only a match on cmp_a_i changes the pin state. act_i selects the response: 00 no change, 01 low, 10 high, 11 toggle. A period match never changes the pin.
- R6: In the clock after en_i rises, the pin state equals init_lvl_i.
- R7: pin_o is the internal pin state XOR pol_i.
- R8: While pause_i is high, the count holds. After release, counting resumes from the held value.
- R9: While en_i is low, the counter is held at 0. Re-enabling restarts counting from 0.
- R10: A match sets its flag in the following clock. The flag stays set until its clear input is high at a clock edge. A set in the same clock as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Timer enable |
| pause_i | input | 1 | Freeze count |
| clr_sel_i | input | 1 | 0: period match clears, 1: A match clears |
| act_i | input | 2 | Pin action on A match |
| init_lvl_i | input | 1 | Pin state loaded on enable rise |
| pol_i | input | 1 | Invert final pin |
| per_i | input | 10 | Period compare value |
| cmp_a_i | input | 10 | Match compare value |
| flag_p_clr_i | input | 1 | Clear period flag |
| flag_a_clr_i | input | 1 | Clear match flag |
| flag_p_o | output | 1 | Sticky period-match flag |
| flag_a_o | output | 1 | Sticky A-match flag |
| pin_o | output | 1 | Timer output pin |

## Verification
The assertions assume that every control and compare input is stable across a clock edge and changes only between edges. They also assume that an enable rise is never combined with a same-cycle match, which holds because the count is zero at that moment and a zero match value is invalid. The bench changes every input on the falling edge. Each scenario starts from a disabled timer with both flags cleared. Compare values are not rewritten while a scenario counts toward a match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         pause_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (!pause_i) cnt_q <= clr_i ? '0 : cnt_q + 1'b1;  // wraps naturally
  end

  assign cnt_o = cnt_q;

  p_off_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  p_pause_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && pause_i |=> $stable(cnt_q));
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !pause_i && !clr_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic         clr_sel_i,
  input  logic         flag_p_clr_i,
  input  logic         flag_a_clr_i,
  output logic         match_a_o,
  output logic         clr_cnt_o,
  output logic         flag_p_o,
  output logic         flag_a_o
);
  localparam int NF = 2;  // 0: period, 1: A

  logic match_p, match_a;
  logic [NF-1:0] set_v, clr_v, flag_q;

  assign match_p = run_i && (per_i != '0) && (cnt_i == per_i);
  assign match_a = run_i && (cmp_a_i != '0) && (cnt_i == cmp_a_i);

  assign clr_cnt_o = clr_sel_i ? match_a : match_p;
  assign match_a_o = match_a;

  assign set_v = {match_a, match_p && !clr_sel_i};
  assign clr_v = {flag_a_clr_i, flag_p_clr_i};

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_v[i]) flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_v[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flag_p_o = flag_q[0];
  assign flag_a_o = flag_q[1];

  p_a_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_a_i == '0 |-> !match_a_o);
  p_no_pflag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sel_i && !flag_q[0] |=> !flag_q[0]);
  p_aflag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_a_o |=> flag_q[1]);
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       match_a_i,
  input  logic [1:0] act_i,
  input  logic       init_lvl_i,
  input  logic       pol_i,
  output logic       pin_o
);
  logic en_q, out_q, out_d, en_rise;
  act_e act;

  assign act     = act_e'(act_i);
  assign en_rise = en_i && !en_q;

  always_comb begin
    out_d = out_q;
    if (en_rise) out_d = init_lvl_i;
    else if (match_a_i) begin
      unique case (act)
        ACT_HOLD:   out_d = out_q;
        ACT_LOW:    out_d = 1'b0;
        ACT_HIGH:   out_d = 1'b1;
        ACT_TOGGLE: out_d = ~out_q;
        default:    out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      out_q <= out_d;
    end
  end

  assign pin_o = out_q ^ pol_i;

  p_init_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !en_q |=> out_q == $past(init_lvl_i));
  p_only_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !en_q) && !match_a_i |=> $stable(out_q));
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pause_i,
  input  logic             clr_sel_i,
  input  logic [1:0]       act_i,
  input  logic             init_lvl_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic             flag_p_clr_i,
  input  logic             flag_a_clr_i,
  output logic             flag_p_o,
  output logic             flag_a_o,
  output logic             pin_o
);
  logic [CNT_W-1:0] cnt;
  logic clr_cnt, match_a;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pause_i(pause_i),
    .clr_i(clr_cnt), .cnt_o(cnt)
  );

  tmr_match #(.W(CNT_W)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i && !pause_i), .cnt_i(cnt),
    .per_i(per_i), .cmp_a_i(cmp_a_i), .clr_sel_i(clr_sel_i),
    .flag_p_clr_i(flag_p_clr_i), .flag_a_clr_i(flag_a_clr_i),
    .match_a_o(match_a), .clr_cnt_o(clr_cnt),
    .flag_p_o(flag_p_o), .flag_a_o(flag_a_o)
  );

  tmr_pin u_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .match_a_i(match_a),
    .act_i(act_i), .init_lvl_i(init_lvl_i), .pol_i(pol_i), .pin_o(pin_o)
  );

  p_pin_pol_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(u_pin.out_q) && $changed(pol_i) |-> pin_o != $past(pin_o));
endmodule

// File: tb/tb_tmr_cmp_out.sv
module tb_tmr_cmp_out;
  logic clk = 0, rst_n = 0;
  logic en = 0, pause = 0, clr_sel = 0, init_lvl = 0, pol = 0;
  logic [1:0] act = 0;
  logic [9:0] per = 0, cmp_a = 0;
  logic fpc = 0, fac = 0;
  logic flag_p, flag_a, pin;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  tmr_cmp_out dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pause_i(pause), .clr_sel_i(clr_sel),
    .act_i(act), .init_lvl_i(init_lvl), .pol_i(pol), .per_i(per), .cmp_a_i(cmp_a),
    .flag_p_clr_i(fpc), .flag_a_clr_i(fac),
    .flag_p_o(flag_p), .flag_a_o(flag_a), .pin_o(pin)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic act_v, logic exp_v, string tag);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act_v, exp_v);
    end
  endtask

  // disable, clear flags, apply config, then raise enable (edge count starts at 0)
  task automatic start(logic cs, logic [1:0] a, logic il, logic pl, logic [9:0] p, logic [9:0] ca);
    en = 0; pause = 0; fpc = 1; fac = 1;
    tick(1);
    fpc = 0; fac = 0;
    clr_sel = cs; act = a; init_lvl = il; pol = pl; per = p; cmp_a = ca;
    tick(1);
    en = 1;
  endtask

  task automatic t_reset;
    chk(pin, 1'b0, "R7 reset pin");
    chk(flag_p, 1'b0, "R10 reset flag_p");
    chk(flag_a, 1'b0, "R10 reset flag_a");
  endtask

  task automatic t_clr_p_toggle;
    start(0, 2'b11, 0, 0, 10'd9, 10'd5);
    tick(1);  chk(pin, 1'b0, "R6 init low");
    tick(4);  chk(flag_a, 1'b0, "R10 no early flag_a");
    tick(1);  chk(pin, 1'b1, "R5 toggle on A");
    chk(flag_a, 1'b1, "R10 flag_a set");
    tick(3);  chk(flag_p, 1'b0, "R2 no early flag_p");
    tick(1);  chk(flag_p, 1'b1, "R2 flag_p on period");
    chk(pin, 1'b1, "R5 period match leaves pin");
    tick(5);  chk(pin, 1'b1, "R2 before second A");
    tick(1);  chk(pin, 1'b0, "R2 period 10 toggle again");
  endtask

  task automatic t_clr_a;
    start(1, 2'b10, 0, 0, 10'd3, 10'd6);
    tick(7);  chk(pin, 1'b1, "R5 high on A");
    chk(flag_a, 1'b1, "R3 flag_a");
    fac = 1; tick(1); fac = 0;
    chk(flag_a, 1'b0, "R10 w1c clears");
    tick(5);  chk(flag_a, 1'b0, "R3 before restart match");
    tick(1);  chk(flag_a, 1'b1, "R3 period A+1");
    tick(30); chk(flag_p, 1'b0, "R3 flag_p suppressed");
  endtask

  task automatic t_low_pol;
    start(0, 2'b01, 1, 1, 10'd20, 10'd4);
    tick(1);  chk(pin, 1'b0, "R7 init high inverted");
    tick(4);  chk(pin, 1'b1, "R5 low action inverted");
    pol = 0; tick(1);
    chk(pin, 1'b0, "R7 pol off");
  endtask

  task automatic t_hold;
    start(0, 2'b00, 1, 0, 10'd20, 10'd4);
    tick(5);  chk(flag_a, 1'b1, "R5 hold flag set");
    chk(pin, 1'b1, "R5 code 00 no change");
  endtask

  task automatic t_a_zero;
    start(0, 2'b11, 0, 0, 10'd5, 10'd0);
    tick(20);
    chk(flag_a, 1'b0, "R4 no A flag");
    chk(pin, 1'b0, "R4 pin untouched");
    chk(flag_p, 1'b1, "R2 period still runs");
  endtask

  task automatic t_overflow;
    start(0, 2'b11, 0, 0, 10'd0, 10'd2);
    tick(3);    chk(pin, 1'b1, "R1 first A");
    tick(1023); chk(pin, 1'b1, "R1 before wrap match");
    tick(1);    chk(pin, 1'b0, "R1 wrap after 0x3FF");
    chk(flag_p, 1'b0, "R2 per zero no flag");
  endtask

  task automatic t_pause;
    start(0, 2'b10, 0, 0, 10'd50, 10'd10);
    tick(4);  pause = 1;
    tick(20); pause = 0;
    tick(6);  chk(flag_a, 1'b0, "R8 held count");
    tick(1);  chk(flag_a, 1'b1, "R8 resumed");
  endtask

  task automatic t_restart;
    start(0, 2'b11, 0, 0, 10'd30, 10'd5);
    tick(6);  chk(pin, 1'b1, "R9 first run toggle");
    tick(3);  en = 0; tick(2);
    en = 1; init_lvl = 0;
    tick(1);  chk(pin, 1'b0, "R6 reload on re-enable");
    tick(4);  chk(pin, 1'b0, "R9 restart from zero");
    tick(1);  chk(pin, 1'b1, "R9 match after restart");
  endtask

  task automatic t_set_wins;
    start(0, 2'b00, 0, 0, 10'd30, 10'd3);
    tick(3);  fac = 1;
    tick(1);  fac = 0;
    chk(flag_a, 1'b1, "R10 set beats clear");
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1;
    tick(1);
    t_clr_p_toggle();
    t_clr_a();
    t_low_pol();
    t_hold();
    t_a_zero();
    t_overflow();
    t_pause();
    t_restart();
    t_set_wins();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule